// File: doc/BRIEF.md
# Real-Time Clock Prescaler and Update Sequencer

This block sits on the oscillator clock of a real-time clock. A 3-bit divider-select input picks one of three oscillator rates. A two-stage divider first brings the oscillator down to a base rate equal to a 32.768 kHz crystal, then counts base periods up to one second. Each second it issues a one-cycle update strobe to an external time-of-day counter. It also keeps an update-in-progress flag that software can poll to know when the time registers are unsafe to read.

The flag rises a fixed number of base periods before each update. It stays high for a fixed window after the update. A software-controlled inhibit input suppresses updates and clears the flag. Two divider-select codes hold the divider chain in reset. The remaining non-operating codes freeze the chain in place. Every count is a parameter, so a small configuration can be exercised in full.

Top module: `rtc_tick_ctrl`

## Requirements
- R1: With divider-select 000, 001 or 010, the divider takes PRE_FAST, PRE_MID or PRE_SLOW oscillator cycles per base period, and SEC_BASE base periods per second. The update strobe therefore comes SEC_BASE times that prescale count of cycles after the divider starts.
- R2: Codes 110 and 111 hold the divider in reset, with bit 0 ignored. While held, `div_held` is 1, no strobe is issued, and the flag is cleared on the next clock. For every other code `div_held` is 0.
- R3: After the divider leaves reset, the first strobe comes exactly one second of counting later. Later strobes follow at one-second intervals.
- R4: The flag rises LEAD_BASE base periods before each update strobe.
- R5: The flag falls WINDOW_BASE base periods after the update strobe.
- R6: The update strobe is high for exactly one oscillator cycle, and only while the flag is high.
- R7: While `set_upd` is 1, no strobe is issued and the flag is 0 from the next clock on. A pending update that this cancels is not made up later, and counting goes on.
- R8: Codes 011, 100 and 101 freeze both divider stages. No strobe is issued and the flag keeps its value, unless `set_upd` clears it. Returning to an operating code resumes counting from the frozen position.
- R9: `por_n` low clears the flag and the strobe. No other reset input acts on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock, rising edge active |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| div_sel | input | 3 | Divider-select code |
| set_upd | input | 1 | Update inhibit from the control register |
| upd_stb | output | 1 | One-cycle update strobe to the time-of-day counter |
| uip | output | 1 | Update-in-progress flag |
| div_held | output | 1 | Divider chain held in reset |

## Verification
The case that is hardest to reach from the ports is a freeze or an inhibit that lands inside the window where the flag is high. The stimulus releases the divider from its held state at a known cycle. From that point every flag edge and strobe lands at a cycle offset known in advance. The bench then switches to a frozen code, or raises the inhibit, at an offset where the flag is already high. A frozen interval spread across all three reserved codes must delay the next strobe by exactly its own length.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

   typedef enum logic [2:0] {
      DM_FAST   = 3'd0,
      DM_MID    = 3'd1,
      DM_SLOW   = 3'd2,
      DM_HOLD   = 3'd3,
      DM_FREEZE = 3'd4
   } div_mode_e;

   function automatic div_mode_e decode_sel(input logic [2:0] code);
      div_mode_e m;
      case (code)
         3'b000:         m = DM_FAST;
         3'b001:         m = DM_MID;
         3'b010:         m = DM_SLOW;
         3'b110, 3'b111: m = DM_HOLD;
         default:        m = DM_FREEZE;
      endcase
      return m;
   endfunction

   function automatic logic mode_runs(input div_mode_e m);
      return (m == DM_FAST) || (m == DM_MID) || (m == DM_SLOW);
   endfunction

endpackage

// File: rtl/rtc_div_decode.sv
module rtc_div_decode
   import rtc_tick_pkg::*;
#(
   parameter int PRE_FAST = 128,
   parameter int PRE_MID  = 32,
   parameter int PRE_SLOW = 1,
   parameter int PRE_W    = 7
) (
   input  logic [2:0]       div_sel,
   output logic             run,
   output logic             hold,
   output logic [PRE_W-1:0] pre_lim
);

   localparam logic [PRE_W-1:0] LIM_FAST = PRE_W'(PRE_FAST - 1);
   localparam logic [PRE_W-1:0] LIM_MID  = PRE_W'(PRE_MID - 1);
   localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'(PRE_SLOW - 1);

   div_mode_e mode;

   always_comb begin
      mode = decode_sel(div_sel);
      run  = mode_runs(mode);
      hold = (mode == DM_HOLD);
      case (mode)
         DM_FAST: pre_lim = LIM_FAST;
         DM_MID:  pre_lim = LIM_MID;
         default: pre_lim = LIM_SLOW;
      endcase
   end

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain #(
   parameter int PRE_FAST    = 128,
   parameter int PRE_W       = 7,
   parameter int SEC_BASE    = 32768,
   parameter int LEAD_BASE   = 8,
   parameter int WINDOW_BASE = 66
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             run,
   input  logic             hold,
   input  logic [PRE_W-1:0] pre_lim,
   output logic             tick_rise,
   output logic             tick_upd,
   output logic             tick_fall
);

   localparam int SEC_W = (SEC_BASE > 1) ? $clog2(SEC_BASE) : 1;
   localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_BASE - 1);
   localparam logic [SEC_W-1:0] SEC_RISE = SEC_W'(SEC_BASE - LEAD_BASE - 1);
   localparam logic [SEC_W-1:0] SEC_FALL = SEC_W'(WINDOW_BASE - 1);

   logic             base_tick;
   logic [SEC_W-1:0] sec_q;

   generate
      if (PRE_FAST > 1) begin : g_pre
         logic [PRE_W-1:0] pre_q;
         assign base_tick = run && (pre_q >= pre_lim);
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)          pre_q <= '0;
            else if (hold)       pre_q <= '0;
            else if (base_tick)  pre_q <= '0;
            else if (run)        pre_q <= pre_q + 1'b1;
         end
      end else begin : g_nopre
         logic unused_lim;
         assign unused_lim = ^pre_lim;
         assign base_tick  = run;
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         sec_q <= '0;
      else if (hold)      sec_q <= '0;
      else if (base_tick) sec_q <= (sec_q == SEC_LAST) ? '0 : sec_q + 1'b1;
   end

   assign tick_upd  = base_tick && (sec_q == SEC_LAST);
   assign tick_rise = base_tick && (sec_q == SEC_RISE);
   assign tick_fall = base_tick && (sec_q == SEC_FALL);

endmodule

// File: rtl/rtc_uip_seq.sv
module rtc_uip_seq (
   input  logic clk,
   input  logic por_n,
   input  logic set_upd,
   input  logic hold,
   input  logic tick_rise,
   input  logic tick_upd,
   input  logic tick_fall,
   output logic uip,
   output logic upd_stb
);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         uip     <= 1'b0;
         upd_stb <= 1'b0;
      end else begin
         upd_stb <= 1'b0;
         if (set_upd || hold)       uip <= 1'b0;
         else if (tick_upd && uip)  upd_stb <= 1'b1;
         else if (tick_rise)        uip <= 1'b1;
         else if (tick_fall)        uip <= 1'b0;
      end
   end

endmodule

// File: rtl/rtc_tick_ctrl.sv
module rtc_tick_ctrl #(
   parameter int PRE_FAST    = 128,
   parameter int PRE_MID     = 32,
   parameter int PRE_SLOW    = 1,
   parameter int SEC_BASE    = 32768,
   parameter int LEAD_BASE   = 8,
   parameter int WINDOW_BASE = 66
) (
   input  logic       osc_clk,
   input  logic       por_n,
   input  logic [2:0] div_sel,
   input  logic       set_upd,
   output logic       upd_stb,
   output logic       uip,
   output logic       div_held
);

   localparam int PRE_W = (PRE_FAST > 1) ? $clog2(PRE_FAST) : 1;

   generate
      if (PRE_SLOW < 1 || PRE_MID < PRE_SLOW || PRE_FAST < PRE_MID) begin : g_bad_pre
         $error("prescale counts must satisfy 1 <= PRE_SLOW <= PRE_MID <= PRE_FAST");
      end
      if (LEAD_BASE < 1 || WINDOW_BASE < 1) begin : g_bad_win
         $error("lead and window counts must be at least 1");
      end
      if (WINDOW_BASE + LEAD_BASE >= SEC_BASE) begin : g_bad_sec
         $error("lead plus window must be shorter than one second");
      end
   endgenerate

   logic             run, hold;
   logic [PRE_W-1:0] pre_lim;
   logic             tick_rise, tick_upd, tick_fall;

   rtc_div_decode #(
      .PRE_FAST(PRE_FAST), .PRE_MID(PRE_MID), .PRE_SLOW(PRE_SLOW), .PRE_W(PRE_W)
   ) dec_i (
      .div_sel(div_sel), .run(run), .hold(hold), .pre_lim(pre_lim)
   );

   rtc_div_chain #(
      .PRE_FAST(PRE_FAST), .PRE_W(PRE_W), .SEC_BASE(SEC_BASE),
      .LEAD_BASE(LEAD_BASE), .WINDOW_BASE(WINDOW_BASE)
   ) chain_i (
      .clk(osc_clk), .por_n(por_n), .run(run), .hold(hold), .pre_lim(pre_lim),
      .tick_rise(tick_rise), .tick_upd(tick_upd), .tick_fall(tick_fall)
   );

   rtc_uip_seq seq_i (
      .clk(osc_clk), .por_n(por_n), .set_upd(set_upd), .hold(hold),
      .tick_rise(tick_rise), .tick_upd(tick_upd), .tick_fall(tick_fall),
      .uip(uip), .upd_stb(upd_stb)
   );

   assign div_held = hold;

endmodule

// File: rtl/rtc_tick_ctrl_chk.sv
module rtc_tick_ctrl_chk (
   input logic       osc_clk,
   input logic       por_n,
   input logic [2:0] div_sel,
   input logic       set_upd,
   input logic       upd_stb,
   input logic       uip,
   input logic       div_held
);

   logic frozen_code;
   assign frozen_code = (div_sel == 3'b011) || (div_sel[2:1] == 2'b10);

   // R6
   stb_single_chk: assert property (@(posedge osc_clk) disable iff (!por_n)
      upd_stb |=> !upd_stb);

   // R6
   stb_in_flag_chk: assert property (@(posedge osc_clk) disable iff (!por_n)
      upd_stb |-> uip);

   // R7
   set_blocks_chk: assert property (@(posedge osc_clk) disable iff (!por_n)
      set_upd |=> (!upd_stb && !uip));

   // R2
   held_quiet_chk: assert property (@(posedge osc_clk) disable iff (!por_n)
      div_held |=> (!upd_stb && !uip));

   // R2
   held_code_chk: assert property (@(posedge osc_clk) disable iff (!por_n)
      div_held == (div_sel[2] && div_sel[1]));

   // R8
   freeze_hold_chk: assert property (@(posedge osc_clk) disable iff (!por_n)
      (frozen_code && !set_upd) |=> ($stable(uip) && !upd_stb));

   // R9
   always_comb begin
      if (!por_n) begin
         por_clear_chk: assert (!uip && !upd_stb);
      end
   end

endmodule

bind rtc_tick_ctrl rtc_tick_ctrl_chk chk_i (
   .osc_clk(osc_clk), .por_n(por_n), .div_sel(div_sel), .set_upd(set_upd),
   .upd_stb(upd_stb), .uip(uip), .div_held(div_held)
);

// File: tb/rtc_tick_ctrl_tb.sv
`timescale 1ns/1ps
module rtc_tick_ctrl_tb_top;

   localparam int PF = 4, PM = 2, PS = 1;
   localparam int N = 20, LD = 3, WN = 5;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic [2:0] div_sel = 3'b110;
   logic       set_upd = 1'b0;
   logic       upd_stb, uip, div_held;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rtc_tick_ctrl #(
      .PRE_FAST(PF), .PRE_MID(PM), .PRE_SLOW(PS),
      .SEC_BASE(N), .LEAD_BASE(LD), .WINDOW_BASE(WN)
   ) dut_i (
      .osc_clk(clk), .por_n(por_n), .div_sel(div_sel), .set_upd(set_upd),
      .upd_stb(upd_stb), .uip(uip), .div_held(div_held)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic hold_div();
      @(negedge clk);
      div_sel = 3'b110;
      repeat (3) @(negedge clk);
   endtask

   task automatic measure(input logic [2:0] code, input int p);
      int c0, rise, fall, s1, s2, wide;
      bit prev;
      hold_div();
      div_sel = code;
      c0 = cyc;
      rise = -1; fall = -1; s1 = -1; s2 = -1; wide = 0; prev = 0;
      for (int j = 1; j <= 2 * N * p + 2; j++) begin
         @(negedge clk);
         if (uip && rise < 0) rise = cyc - c0;
         if (!uip && rise >= 0 && fall < 0) fall = cyc - c0;
         if (upd_stb) begin
            if (s1 < 0) s1 = cyc - c0;
            else if (s2 < 0) s2 = cyc - c0;
            if (prev) wide++;
         end
         prev = upd_stb;
      end
      // R1 R3: first strobe one second after release
      chk(s1 == N * p, "R1/R3 first strobe", s1, N * p);
      // R3: next strobe one second later
      chk(s2 == 2 * N * p, "R3 second strobe", s2, 2 * N * p);
      // R4: flag lead
      chk(rise == (N - LD) * p, "R4 flag rise", rise, (N - LD) * p);
      // R5: flag window
      chk(fall == (N + WN) * p, "R5 flag fall", fall, (N + WN) * p);
      // R6: single-cycle strobe
      chk(wide == 0, "R6 strobe width", wide, 0);
   endtask

   initial begin : main
      int c0, nstb, at;
      logic keep;
      repeat (3) @(negedge clk);
      // R9: power-on reset state
      chk(uip == 1'b0, "R9 uip in reset", int'(uip), 0);
      chk(upd_stb == 1'b0, "R9 strobe in reset", int'(upd_stb), 0);
      por_n = 1'b1;

      // R2: held indication for every code
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         div_sel = 3'(c);
         #1;
         chk(div_held == (c >= 6), "R2 div_held code", int'(div_held), int'(c >= 6));
      end

      // R1 per operating code
      measure(3'b000, PF);
      measure(3'b001, PM);
      measure(3'b010, PS);

      // R7: inhibit while flag high
      hold_div();
      div_sel = 3'b010;
      c0 = cyc;
      nstb = 0; at = -1;
      while (cyc - c0 < N - LD) @(negedge clk);
      chk(uip == 1'b1, "R4 flag high before inhibit", int'(uip), 1);
      set_upd = 1'b1;
      @(negedge clk);
      chk(uip == 1'b0, "R7 flag drops next clock", int'(uip), 0);
      while (cyc - c0 < 2 * N + 5) begin
         if (cyc - c0 == 25) set_upd = 1'b0;
         @(negedge clk);
         if (upd_stb) begin nstb++; at = cyc - c0; end
      end
      chk(nstb == 1, "R7 strobe count with inhibit", nstb, 1);
      chk(at == 2 * N, "R7 strobe after inhibit released", at, 2 * N);

      // R2: divider reset clears flag
      hold_div();
      div_sel = 3'b010;
      c0 = cyc;
      while (cyc - c0 < N - LD + 1) @(negedge clk);
      div_sel = 3'b111;
      @(negedge clk);
      chk(uip == 1'b0, "R2 flag cleared by hold", int'(uip), 0);
      chk(div_held == 1'b1, "R2 held with bit0 set", int'(div_held), 1);

      // R8: freeze over all reserved codes while flag high
      hold_div();
      div_sel = 3'b000;
      c0 = cyc;
      nstb = 0; at = -1;
      while (cyc - c0 < 70) @(negedge clk);
      keep = uip;
      chk(keep == 1'b1, "R4 flag high before freeze", int'(keep), 1);
      div_sel = 3'b011;
      while (cyc - c0 < 270) begin
         if (cyc - c0 == 170) div_sel = 3'b101;
         if (cyc - c0 == 220) div_sel = 3'b100;
         @(negedge clk);
         if (upd_stb) nstb++;
         if (uip != keep) nstb += 100;
      end
      chk(nstb == 0, "R8 no strobe and flag held while frozen", nstb, 0);
      div_sel = 3'b000;
      while (cyc - c0 < 290) begin
         @(negedge clk);
         if (upd_stb && at < 0) at = cyc - c0;
      end
      chk(at == N * PF + 200, "R8 resume after freeze", at, N * PF + 200);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : watchdog
      #(8 * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule